// File: doc/BRIEF.md
# External Interrupt Trigger Detector

The block takes a bank of asynchronous external interrupt lines, brings each one into the clock domain through a two-flop synchroniser, and compares it against a trigger condition chosen per line. Each line drives one request bit toward the interrupt controller. In a level mode the bit stays high while the level holds. In an edge mode the bit pulses for one cycle on each qualifying transition.

Trigger modes sit in 32-bit configuration words, eight lines per word. Each line owns a 4-bit slot that holds a 3-bit mode and one reserved bit. Software writes the words over a small register bus. A per-slot write enable lets one line be reprogrammed without a read-modify-write of the seven lines that share its word. The bus can also read back any word combinationally.

Top module: `exti_trigger`

## Requirements
- R1: The mode of line n occupies bits [4*(n mod 8)+2 : 4*(n mod 8)] of word n/8. Reading a word returns every mode in its slot, and bit 3 of every slot reads 0.
- R2: A write updates the slot of line n only when cfg_nib_en_i[n mod 8] is set. Slots whose enable is clear keep their value.
- R3: While rst_ni is low, every mode is 000 and every request is 0.
- R4: Mode 000 (low level) holds the request high in every cycle in which the synchronised line is 0.
- R5: Mode 001 (high level) holds the request high in every cycle in which the synchronised line is 1.
- R6: Modes 010 and 011 (falling edge) give a one-cycle request for each 1-to-0 transition of the synchronised line.
- R7: Modes 100 and 101 (rising edge) give a one-cycle request for each 0-to-1 transition of the synchronised line.
- R8: Modes 110 and 111 (both edges) give a one-cycle request for each transition in either direction.
- R9: The request responds to a line value driven before clock edge t at the output after edge t+2. That is two synchroniser stages plus one output register.
- R10: In the cycle right after a write changes a line's mode, edge detection for that line is suppressed. Level modes are not affected.
- R11: A write to an address at or above the number of configuration words changes nothing, and a read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | N_IN | Asynchronous external interrupt lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration word index |
| cfg_nib_en_i | input | WORD_W/STRIDE | Per-slot write enable |
| cfg_wdata_i | input | WORD_W | Write data |
| cfg_rdata_o | output | WORD_W | Read data for cfg_addr_i (combinational) |
| irq_req_o | output | N_IN | Request per line |

## Verification
The hardest case to reach is an edge that arrives at the output stage in the same cycle in which its line's mode has just been rewritten. Only there does suppression decide the result. Reaching it needs a write, with that line's slot enabled and a different value, landing exactly two edges after the line toggles. The stimulus gets there by mixing frequent random writes with random slot enables and random line toggles over every line of every word for thousands of cycles. Directed writes first set up known patterns, including a single-slot update and an out-of-range address.

// File: rtl/exti_pkg.sv
package exti_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [2:0] {
    TRIG_LOW  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  function automatic trig_e trig_decode(input logic [MODE_W-1:0] m);
    case (m[2:1])
      2'b00:   return m[0] ? TRIG_HIGH : TRIG_LOW;
      2'b01:   return TRIG_FALL;
      2'b10:   return TRIG_RISE;
      default: return TRIG_BOTH;
    endcase
  endfunction
endpackage

// File: rtl/exti_cfg_regs.sv
module exti_cfg_regs #(
  parameter int N_IN   = 24,
  parameter int WORD_W = 32,
  parameter int STRIDE = 4,
  parameter int ADDR_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WORD_W/STRIDE-1:0]      nib_en_i,
  input  logic [WORD_W-1:0]             wdata_i,
  output logic [WORD_W-1:0]             rdata_o,
  output logic [N_IN*exti_pkg::MODE_W-1:0] mode_o
);
  localparam int FW  = exti_pkg::MODE_W;
  localparam int PER = WORD_W / STRIDE;

  logic [FW-1:0] mode_q [N_IN];

  for (genvar n = 0; n < N_IN; n++) begin : g_field
    localparam int W = n / PER;
    localparam int S = n % PER;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          mode_q[n] <= '0;
      else if (we_i && addr_i == ADDR_W'(W) && nib_en_i[S]) mode_q[n] <= wdata_i[STRIDE*S +: FW];
    end
    assign mode_o[n*FW +: FW] = mode_q[n];
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < N_IN; n++)
      if (addr_i == ADDR_W'(n / PER)) rdata_o[STRIDE*(n % PER) +: FW] = mode_q[n];
  end

  // bits of each slot above the mode field are reserved
  logic [WORD_W-1:0] rsvd_mask;
  always_comb begin
    rsvd_mask = '1;
    for (int s = 0; s < PER; s++) rsvd_mask[STRIDE*s +: FW] = '0;
  end
  logic unused_rsvd;
  assign unused_rsvd = ^(wdata_i & rsvd_mask);
endmodule

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int N_IN   = 24,
  parameter int STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] async_i,
  output logic [N_IN-1:0] sync_o
);
  logic [N_IN-1:0] stage_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[k] <= '0;
      else         stage_q[k] <= (k == 0) ? async_i : stage_q[(k == 0) ? 0 : k-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/exti_detect.sv
module exti_detect
  import exti_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              req_o
);
  logic              prev_q;
  logic [MODE_W-1:0] mode_prev_q;
  logic              hold;
  logic              req_d;

  assign hold = (mode_i != mode_prev_q);

  always_comb begin
    unique case (trig_decode(mode_i))
      TRIG_LOW:  req_d = !sync_i;
      TRIG_HIGH: req_d = sync_i;
      TRIG_FALL: req_d = !hold && prev_q && !sync_i;
      TRIG_RISE: req_d = !hold && !prev_q && sync_i;
      default:   req_d = !hold && (prev_q ^ sync_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= 1'b0;
      mode_prev_q <= '0;
      req_o       <= 1'b0;
    end else begin
      prev_q      <= sync_i;
      mode_prev_q <= mode_i;
      req_o       <= req_d;
    end
  end
endmodule

// File: rtl/exti_trigger.sv
module exti_trigger #(
  parameter int N_IN        = 24,
  parameter int WORD_W      = 32,
  parameter int STRIDE      = 4,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_IN-1:0]          irq_pin_i,
  input  logic                     cfg_we_i,
  input  logic [ADDR_W-1:0]        cfg_addr_i,
  input  logic [WORD_W/STRIDE-1:0] cfg_nib_en_i,
  input  logic [WORD_W-1:0]        cfg_wdata_i,
  output logic [WORD_W-1:0]        cfg_rdata_o,
  output logic [N_IN-1:0]          irq_req_o
);
  localparam int FW = exti_pkg::MODE_W;

  logic [N_IN*FW-1:0] mode_w;
  logic [N_IN-1:0]    sync_w;

  exti_cfg_regs #(.N_IN(N_IN), .WORD_W(WORD_W), .STRIDE(STRIDE), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .nib_en_i (cfg_nib_en_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .mode_o   (mode_w)
  );

  exti_sync #(.N_IN(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_pin_i),
    .sync_o  (sync_w)
  );

  for (genvar n = 0; n < N_IN; n++) begin : g_ch
    exti_detect u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (sync_w[n]),
      .mode_i (mode_w[n*FW +: FW]),
      .req_o  (irq_req_o[n])
    );
  end
endmodule

// File: rtl/exti_trigger_chk.sv
module exti_trigger_chk
  import exti_pkg::*;
#(
  parameter int N_IN = 24
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_IN-1:0]        req_i,
  input logic [N_IN-1:0]        sync_i,
  input logic [N_IN*MODE_W-1:0] mode_i
);
  a_r3_quiet_in_reset: assert property (@(posedge clk_i) !rst_ni |-> req_i == '0);

  for (genvar i = 0; i < N_IN; i++) begin : g_chk
    a_r4_low_needs_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[i] && trig_decode($past(mode_i[i*MODE_W +: MODE_W])) == TRIG_LOW)
        |-> !$past(sync_i[i]));

    a_r5_high_needs_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[i] && trig_decode($past(mode_i[i*MODE_W +: MODE_W])) == TRIG_HIGH)
        |-> $past(sync_i[i]));

    a_r6_fall_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[i] && trig_decode($past(mode_i[i*MODE_W +: MODE_W])) == TRIG_FALL)
        |-> (!$past(sync_i[i]) && $past(sync_i[i], 2)));

    a_r7_rise_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[i] && trig_decode($past(mode_i[i*MODE_W +: MODE_W])) == TRIG_RISE)
        |-> ($past(sync_i[i]) && !$past(sync_i[i], 2)));

    a_r10_edge_held_after_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($past(mode_i[i*MODE_W +: MODE_W]) != $past(mode_i[i*MODE_W +: MODE_W], 2)) &&
       ($past(mode_i[i*MODE_W + 1]) || $past(mode_i[i*MODE_W + 2])))
        |-> !req_i[i]);
  end
endmodule

bind exti_trigger exti_trigger_chk #(.N_IN(N_IN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (irq_req_o),
  .sync_i (sync_w),
  .mode_i (mode_w)
);

// File: tb/tb_exti_trigger.sv
`timescale 1ns/1ps
module tb_exti_trigger;
  localparam int N  = 24;
  localparam int NR = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] irq_pin_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_nib_en_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [N-1:0] irq_req_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench history: d0..d3 line values, m0..m2 mode model
  logic [N-1:0] d0 = '0, d1 = '0, d2 = '0, d3 = '0;
  logic [2:0]   m0 [N];
  logic [2:0]   m1 [N];
  logic [2:0]   m2 [N];

  always #2 clk_i = ~clk_i;

  exti_trigger dut (
    .clk_i, .rst_ni, .irq_pin_i, .cfg_we_i, .cfg_addr_i,
    .cfg_nib_en_i, .cfg_wdata_i, .cfg_rdata_o, .irq_req_o
  );

  function automatic logic exp_req(logic [2:0] m, logic chg, logic cur, logic prv);
    case (m[2:1])
      2'b00:   return m[0] ? cur : !cur;
      2'b01:   return !chg && prv && !cur;
      2'b10:   return !chg && !prv && cur;
      default: return !chg && (prv ^ cur);
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] m, logic chg);
    if (chg && (m[2] || m[1])) return "R10";
    case (m[2:1])
      2'b00:   return m[0] ? "R5/latency R9" : "R4/latency R9";
      2'b01:   return "R6/latency R9";
      2'b10:   return "R7/latency R9";
      default: return "R8/latency R9";
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    logic [31:0] r = '0;
    for (int n = 0; n < N; n++)
      if (int'(a) == n / 8 && a < NR) r[4*(n%8) +: 3] = m0[n];
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] pins, logic we, logic [1:0] a, logic [7:0] ne, logic [31:0] wd);
    irq_pin_i = pins; cfg_we_i = we; cfg_addr_i = a; cfg_nib_en_i = ne; cfg_wdata_i = wd;
    @(posedge clk_i);
    d3 = d2; d2 = d1; d1 = d0; d0 = pins;
    m2 = m1; m1 = m0;
    for (int n = 0; n < N; n++)
      if (we && int'(a) == n / 8 && ne[n % 8]) m0[n] = wd[4*(n%8) +: 3];
    @(negedge clk_i);
    for (int n = 0; n < N; n++) begin
      logic e;
      e = exp_req(m1[n], m1[n] != m2[n], d2[n], d3[n]);
      check(irq_req_o[n] === e, $sformatf("%s ch%0d", tag_of(m1[n], m1[n] != m2[n]), n),
            32'(irq_req_o[n]), 32'(e));
    end
    check(cfg_rdata_o === exp_rd(a), (a >= NR) ? "R11 readback" : "R1 R2 readback",
          cfg_rdata_o, exp_rd(a));
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < N; n++) begin m0[n] = '0; m1[n] = '0; m2[n] = '0; end
    // R3: reset state, even with writes attempted
    for (int k = 0; k < 4; k++) begin
      cfg_we_i = 1'b1; cfg_nib_en_i = '1; cfg_wdata_i = '1; irq_pin_i = '1;
      cfg_addr_i = 2'(k);
      @(negedge clk_i);
      check(irq_req_o === '0, "R3 req in reset", 32'(irq_req_o), 0);
      check(cfg_rdata_o === '0, "R3 cfg in reset", cfg_rdata_o, 0);
    end
    irq_pin_i = '0; cfg_we_i = 1'b0;
    rst_ni = 1'b1;
    // directed: full word, reserved bits, single slot, out-of-range address
    step('0, 1'b1, 2'd0, 8'hFF, 32'hFEDC_BA98);
    step('0, 1'b0, 2'd0, 8'h00, 32'h0);
    step('0, 1'b1, 2'd0, 8'h02, 32'h0000_0050);
    step('0, 1'b1, 2'd3, 8'hFF, 32'hFFFF_FFFF);
    step('0, 1'b0, 2'd3, 8'h00, 32'h0);
    step('1, 1'b1, 2'd1, 8'hFF, 32'h6666_6666);
    step('0, 1'b1, 2'd2, 8'hFF, 32'h4444_2222);
    for (int k = 0; k < 6; k++) step((k % 2) ? '1 : '0, 1'b0, 2'd2, 8'h00, 32'h0);
    // same value rewrite: no suppression expected
    step('1, 1'b1, 2'd1, 8'hFF, 32'h6666_6666);
    step('0, 1'b0, 2'd1, 8'h00, 32'h0);
    step('1, 1'b0, 2'd1, 8'h00, 32'h0);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] p;
      p = d0 ^ N'($urandom) & N'($urandom);
      step(p, ($urandom % 4) == 0, 2'($urandom), 8'($urandom), $urandom);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule